// File: doc/BRIEF.md
# Dual DAC Register Front End

This block connects two 12-bit digital-to-analog converter channels to an 8-bit special-function-register bus. It decodes single-cycle byte writes and combinational byte reads at five fixed addresses. The five registers are one shared control byte and, for each channel, a low data byte and a high data byte. For each channel it drives a latched output code, a range-select bit, a power-enable bit and an output-pass bit to the analog core.

Each channel's code is double-buffered. The data bytes load a buffer, and the buffer moves into the output latch in one of two ways. With the control sync bit set, writing the low byte moves the buffer into the latch on that write. With the sync bit clear, the bytes only load the buffers. A later control write that raises the sync bit then moves both channels into their latches on the same clock edge. An 8-bit mode places the low byte in the top of the code. A clear bit per channel zeroes the driven code without touching what is latched.

Top module: `twin_dac_regs`

## Requirements
- R1: After reset the control byte reads 04h, all four data bytes read 00h, both codes are zero, and the range, power and pass outputs are all 0.
- R2: Addresses F9h/FAh hold the low/high byte of channel 0 and FBh/FCh those of channel 1. Each address reads back the stored byte. A high byte read returns 0 in bits 7:4, because only bits 3:0 are kept.
- R3: With sync (control bit 2) at 1 and mode (control bit 7) at 0, a low-byte write latches {high[3:0], written byte} as the channel code. The code is visible after the write's clock edge.
- R4: A write to a high data byte never changes either output code.
- R5: With sync at 0, data-byte writes leave both output codes unchanged.
- R6: A control write that sets sync to 1 while it was 0 latches both channels' buffered codes on the same edge, using the mode bit being written. A control write made while sync is already 1 latches nothing.
- R7: With mode at 1, a latch takes {low byte, 0000b} as the 12-bit code. This applies to both the immediate path and the sync-release path.
- R8: Control bit 3 (channel 0) and bit 4 (channel 1) at 0 force that channel's code to zero. Setting the bit back to 1 restores the previously latched code.
- R9: The range outputs follow control bit 5 (channel 0) and bit 6 (channel 1). The power outputs follow bit 0 (channel 0) and bit 1 (channel 1). The pass outputs follow bits 3 and 4.
- R10: Writes to any address other than F9h–FDh change no register and no output. Reads of such addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the current address |
| code0_o | output | 12 | Channel 0 code to the converter |
| code1_o | output | 12 | Channel 1 code to the converter |
| rng_o | output | 2 | Range select, bit n for channel n |
| pwr_o | output | 2 | Power enable, bit n for channel n |
| pass_o | output | 2 | Output pass (0 = forced to zero), bit n for channel n |

## Verification
The bench builds the block with its default parameters: 8-bit bus bytes, 12-bit codes, the control byte at FDh and the data bytes from F9h. With these values every field position and address in the requirements is exercised exactly as stated. A 4-bit high nibble makes the masked read-back and the 0000b fill of 8-bit mode visible at the ports. The default addresses leave F8h and FEh on either side of the map, so writes just outside it can be shown to have no effect.

// File: rtl/twin_dac_pkg.sv
package twin_dac_pkg;
   // channel count is fixed by the control byte layout
   localparam int unsigned NUM_CH  = 2;
   // control byte field positions (software visible)
   localparam int unsigned CB_PD0   = 0;
   localparam int unsigned CB_SYNC  = 2;
   localparam int unsigned CB_CLR0  = 3;
   localparam int unsigned CB_RNG0  = 5;
   localparam int unsigned CB_MODE  = 7;
endpackage

// File: rtl/twin_dac_dec.sv
module twin_dac_dec
   import twin_dac_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CTRL_ADDR = 'hFD,
   parameter int unsigned DATA_BASE = 'hF9
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              ctrl_sel,
   output logic              ctrl_we,
   output logic [NUM_CH-1:0] lo_sel,
   output logic [NUM_CH-1:0] hi_sel,
   output logic [NUM_CH-1:0] lo_we,
   output logic [NUM_CH-1:0] hi_we
);
   assign ctrl_sel = (addr == ADDR_W'(CTRL_ADDR));
   assign ctrl_we  = wr_en & ctrl_sel;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lo_sel[c] = (addr == ADDR_W'(DATA_BASE + 2*c));
      assign hi_sel[c] = (addr == ADDR_W'(DATA_BASE + 2*c + 1));
      assign lo_we[c]  = wr_en & lo_sel[c];
      assign hi_we[c]  = wr_en & hi_sel[c];
   end
endmodule

// File: rtl/twin_dac_chan.sv
module twin_dac_chan #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              now_en,
   input  logic              now_mode,
   input  logic              bulk_xfer,
   input  logic              bulk_mode,
   input  logic              pass_en,
   output logic [BYTE_W-1:0] lo_q,
   output logic [CODE_W-BYTE_W-1:0] hi_q,
   output logic [CODE_W-1:0] code_o
);
   localparam int unsigned HI_W = CODE_W - BYTE_W;

   logic [CODE_W-1:0] latch_q;
   logic [CODE_W-1:0] now_code;
   logic [CODE_W-1:0] bulk_code;

   // 8-bit mode puts the byte at the top of the code, filling the rest with zeros
   assign now_code  = now_mode  ? {wdata, {HI_W{1'b0}}} : {hi_q, wdata};
   assign bulk_code = bulk_mode ? {lo_q,  {HI_W{1'b0}}} : {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         hi_q    <= '0;
         latch_q <= '0;
      end else begin
         if (lo_we) lo_q <= wdata;
         if (hi_we) hi_q <= wdata[HI_W-1:0];
         if (lo_we && now_en)
            latch_q <= now_code;
         else if (bulk_xfer)
            latch_q <= bulk_code;
      end
   end

   // clear gates the driven value only; the latch keeps its content
   assign code_o = pass_en ? latch_q : '0;
endmodule

// File: rtl/twin_dac_regs.sv
module twin_dac_regs
   import twin_dac_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned CODE_W     = 12,
   parameter int unsigned CTRL_ADDR  = 'hFD,
   parameter int unsigned DATA_BASE  = 'hF9,
   parameter int unsigned CTRL_RESET = 'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic [CODE_W-1:0] code0_o,
   output logic [CODE_W-1:0] code1_o,
   output logic [1:0]        rng_o,
   output logic [1:0]        pwr_o,
   output logic [1:0]        pass_o
);
   localparam int unsigned HI_W = CODE_W - BYTE_W;

   if (HI_W < 1 || HI_W > BYTE_W) begin : g_bad_code_w
      $error("twin_dac_regs: CODE_W must exceed BYTE_W by 1..BYTE_W bits");
   end
   if (BYTE_W <= CB_MODE) begin : g_bad_byte_w
      $error("twin_dac_regs: BYTE_W too narrow for the control byte");
   end
   if (DATA_BASE + 2*NUM_CH > (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("twin_dac_regs: register map does not fit ADDR_W");
   end

   logic              ctrl_sel, ctrl_we;
   logic [NUM_CH-1:0] lo_sel, hi_sel, lo_we, hi_we;
   logic [BYTE_W-1:0] ctrl_q;
   logic              bulk_xfer;
   logic [BYTE_W-1:0] lo_q   [NUM_CH];
   logic [HI_W-1:0]   hi_q   [NUM_CH];
   logic [CODE_W-1:0] code_w [NUM_CH];

   twin_dac_dec #(
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR),
      .DATA_BASE (DATA_BASE)
   ) i_dec (
      .wr_en    (wr_en),
      .addr     (addr),
      .ctrl_sel (ctrl_sel),
      .ctrl_we  (ctrl_we),
      .lo_sel   (lo_sel),
      .hi_sel   (hi_sel),
      .lo_we    (lo_we),
      .hi_we    (hi_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= BYTE_W'(CTRL_RESET);
      else if (ctrl_we) ctrl_q <= wdata;
   end

   // only a 0 -> 1 edge of the sync field releases both buffers
   assign bulk_xfer = ctrl_we & wdata[CB_SYNC] & ~ctrl_q[CB_SYNC];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      twin_dac_chan #(
         .BYTE_W (BYTE_W),
         .CODE_W (CODE_W)
      ) i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .lo_we     (lo_we[c]),
         .hi_we     (hi_we[c]),
         .wdata     (wdata),
         .now_en    (ctrl_q[CB_SYNC]),
         .now_mode  (ctrl_q[CB_MODE]),
         .bulk_xfer (bulk_xfer),
         .bulk_mode (wdata[CB_MODE]),
         .pass_en   (ctrl_q[CB_CLR0 + c]),
         .lo_q      (lo_q[c]),
         .hi_q      (hi_q[c]),
         .code_o    (code_w[c])
      );
      assign rng_o[c]  = ctrl_q[CB_RNG0 + c];
      assign pwr_o[c]  = ctrl_q[CB_PD0 + c];
      assign pass_o[c] = ctrl_q[CB_CLR0 + c];
   end

   assign code0_o = code_w[0];
   assign code1_o = code_w[1];

   always_comb begin
      rdata = '0;
      if (ctrl_sel) rdata = ctrl_q;
      for (int c = 0; c < NUM_CH; c++) begin
         if (lo_sel[c]) rdata = lo_q[c];
         if (hi_sel[c]) rdata = BYTE_W'(hi_q[c]);
      end
   end
endmodule

// File: rtl/twin_dac_chk.sv
module twin_dac_chk
   import twin_dac_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned CODE_W    = 12,
   parameter int unsigned CTRL_ADDR = 'hFD,
   parameter int unsigned DATA_BASE = 'hF9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [BYTE_W-1:0] wdata,
   input logic [BYTE_W-1:0] rdata,
   input logic [CODE_W-1:0] code0_o,
   input logic [CODE_W-1:0] code1_o,
   input logic [1:0]        rng_o,
   input logic [1:0]        pwr_o,
   input logic [1:0]        pass_o
);
   localparam int unsigned HI_W = CODE_W - BYTE_W;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_HI0  = ADDR_W'(DATA_BASE + 1);
   localparam logic [ADDR_W-1:0] A_HI1  = ADDR_W'(DATA_BASE + 3);
   localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(DATA_BASE);
   localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(DATA_BASE + 3);

   logic mapped;
   assign mapped = (addr == A_CTRL) || (addr >= A_LOW && addr <= A_TOP);

   p_hi_nibble_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_HI0 || addr == A_HI1) |-> rdata[BYTE_W-1:HI_W] == '0);

   p_hi_write_keeps_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == A_HI0 || addr == A_HI1)) |=> $stable(code0_o) && $stable(code1_o));

   p_idle_keeps_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(code0_o) && $stable(code1_o));

   p_clear_zero0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_o[0] |-> code0_o == '0);

   p_clear_zero1_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_o[1] |-> code1_o == '0);

   p_ctrl_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_CTRL) |-> rng_o == {rdata[CB_RNG0+1], rdata[CB_RNG0]} &&
                           pwr_o == {rdata[CB_PD0+1], rdata[CB_PD0]} &&
                           pass_o == {rdata[CB_CLR0+1], rdata[CB_CLR0]});

   p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mapped) |=> $stable(code0_o) && $stable(code1_o) &&
                             $stable(rng_o) && $stable(pwr_o) && $stable(pass_o));

   p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> rdata == '0);
endmodule

bind twin_dac_regs twin_dac_chk #(
   .ADDR_W    (ADDR_W),
   .BYTE_W    (BYTE_W),
   .CODE_W    (CODE_W),
   .CTRL_ADDR (CTRL_ADDR),
   .DATA_BASE (DATA_BASE)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .code0_o (code0_o),
   .code1_o (code1_o),
   .rng_o   (rng_o),
   .pwr_o   (pwr_o),
   .pass_o  (pass_o)
);

// File: tb/test_twin_dac_regs.sv
`timescale 1ns/1ps
module test_twin_dac_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rdata;
   logic [11:0] code0_o, code1_o;
   logic [1:0]  rng_o, pwr_o, pass_o;

   always #4 clk = ~clk;   // 125 MHz

   twin_dac_regs i_twin_dac_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .code0_o(code0_o), .code1_o(code1_o),
      .rng_o(rng_o), .pwr_o(pwr_o), .pass_o(pass_o)
   );

   typedef struct {
      string       req;
      int          sel;   // 0 code0, 1 code1, 2 rdata, 3 {rng,pwr,pass}
      logic [11:0] exp;
   } item_t;

   item_t sb[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   // reference state built from the requirements
   logic [7:0]  m_ctrl = 8'h04;
   logic [7:0]  m_lo [2] = '{8'h00, 8'h00};
   logic [3:0]  m_hi [2] = '{4'h0, 4'h0};
   logic [11:0] m_lat[2] = '{12'h000, 12'h000};

   function automatic logic [7:0] m_read(input logic [7:0] a);
      case (a)
         8'hFD:   return m_ctrl;
         8'hF9:   return m_lo[0];
         8'hFA:   return {4'h0, m_hi[0]};
         8'hFB:   return m_lo[1];
         8'hFC:   return {4'h0, m_hi[1]};
         default: return 8'h00;
      endcase
   endfunction

   function automatic void m_write(input logic [7:0] a, input logic [7:0] d);
      case (a)
         8'hFD: begin
            if (d[2] && !m_ctrl[2])
               for (int c = 0; c < 2; c++)
                  m_lat[c] = d[7] ? {m_lo[c], 4'h0} : {m_hi[c], m_lo[c]};
            m_ctrl = d;
         end
         8'hF9, 8'hFB: begin
            automatic int c = (a == 8'hF9) ? 0 : 1;
            m_lo[c] = d;
            if (m_ctrl[2]) m_lat[c] = m_ctrl[7] ? {d, 4'h0} : {m_hi[c], d};
         end
         8'hFA: m_hi[0] = d[3:0];
         8'hFC: m_hi[1] = d[3:0];
         default: ;
      endcase
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      m_write(a, d);
   endtask

   task automatic chk_codes(input string req);
      sb.push_back('{req, 0, m_ctrl[3] ? m_lat[0] : 12'h000});
      sb.push_back('{req, 1, m_ctrl[4] ? m_lat[1] : 12'h000});
   endtask

   task automatic chk_ctl(input string req);
      sb.push_back('{req, 3, {6'h0, m_ctrl[6], m_ctrl[5], m_ctrl[1], m_ctrl[0],
                              m_ctrl[4], m_ctrl[3]}});
   endtask

   task automatic rd(input logic [7:0] a, input string req);
      @(negedge clk);
      addr = a;
      sb.push_back('{req, 2, {4'h0, m_read(a)}});
   endtask

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            automatic item_t it = sb.pop_front();
            automatic logic [11:0] act;
            case (it.sel)
               0:       act = code0_o;
               1:       act = code1_o;
               2:       act = {4'h0, rdata};
               default: act = {6'h0, rng_o, pwr_o, pass_o};
            endcase
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not end actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      chk_codes("R1"); chk_ctl("R1");
      rd(8'hFD, "R1"); rd(8'hF9, "R1"); rd(8'hFA, "R1"); rd(8'hFB, "R1"); rd(8'hFC, "R1");

      // sync on, both channels passing, powered, 12-bit
      wr(8'hFD, 8'h1F); chk_ctl("R9"); chk_codes("R1");
      wr(8'hFA, 8'h3A); chk_codes("R4");
      wr(8'hF9, 8'h5C); chk_codes("R3");
      rd(8'hFA, "R2"); rd(8'hF9, "R2");
      wr(8'hFC, 8'h07); chk_codes("R4");
      wr(8'hFB, 8'hFF); chk_codes("R3");
      rd(8'hFC, "R2"); rd(8'hFB, "R2");

      // deferred update
      wr(8'hFD, 8'h1B); chk_codes("R5");
      wr(8'hF9, 8'h11); chk_codes("R5");
      wr(8'hFA, 8'h02); chk_codes("R5");
      wr(8'hFB, 8'h22); chk_codes("R5");
      wr(8'hFC, 8'hFF); chk_codes("R5");
      rd(8'hFC, "R2");
      wr(8'hFD, 8'h1F); chk_codes("R6");
      wr(8'hFA, 8'h05); chk_codes("R4");
      wr(8'hFD, 8'h1F); chk_codes("R6");

      // 8-bit mode, immediate then deferred
      wr(8'hFD, 8'h9F); chk_codes("R6");
      wr(8'hF9, 8'hC3); chk_codes("R7");
      wr(8'hFD, 8'h9B);
      wr(8'hFB, 8'h81); chk_codes("R5");
      wr(8'hFD, 8'h9F); chk_codes("R7");

      // clear keeps latched code
      wr(8'hFD, 8'h8F); chk_codes("R8"); chk_ctl("R8");
      wr(8'hFD, 8'h9F); chk_codes("R8");
      wr(8'hFD, 8'h97); chk_codes("R8");
      wr(8'hFD, 8'h9F); chk_codes("R8");

      // field mapping
      wr(8'hFD, 8'hC1); chk_ctl("R9"); chk_codes("R9");
      wr(8'hFD, 8'h22); chk_ctl("R9");

      // unmapped addresses
      wr(8'hFD, 8'h1F); chk_codes("R10");
      wr(8'hF8, 8'hFF); chk_codes("R10"); chk_ctl("R10");
      wr(8'hFE, 8'h00); chk_codes("R10"); chk_ctl("R10");
      rd(8'hF8, "R10"); rd(8'hFE, "R10"); rd(8'hFD, "R10"); rd(8'hF9, "R10");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule